// File: doc/BRIEF.md
# Counted Byte Transfer Sequencer

This block moves bytes from a source queue to a sink queue without supervision, one byte per transaction, until a programmed number of transactions has been carried out. Software loads a 32-bit transaction count one byte lane at a time while the block is not running, then pulses `start`. From then on, the sequencer transfers a byte in any cycle where the source holds data, the sink has space and the chosen ready input is high. In every other cycle it waits, and no software action is needed to resume.

The remaining count is always visible on `count` and drops by one with every completed transaction. When the last transaction completes, the block stops and raises a sticky `done` flag. That flag stays high until the next start. A control strobe output marks each transaction cycle. It can change level on every clock.

The control state machine has three states. ST_IDLE is the state after reset. ST_RUN is the state in which transfers happen. ST_DONE is the finished state, and `done` is high there. Its transitions are as follows. IDLE or DONE goes to RUN on `start` when the count is non-zero. IDLE or DONE goes to DONE on `start` when the count is zero. RUN goes to DONE on the transaction that moves the count from one to zero. Every other case holds the current state.

Top module: `xfer_seq`

## Requirements
- R1: After reset, `count` is 0, `busy` and `done` are low, `src_rd` and `snk_wr` are low, and `ctl_strobe` is at its inactive level.
- R2: While `busy` is low, a cycle with `cnt_wr_en` high writes `cnt_wr_data` into one byte lane of the count. The lane is chosen by `cnt_wr_sel`: 0 selects bits 7:0, 1 selects 15:8, 2 selects 23:16 and 3 selects 31:24. The new value shows on `count` after that clock edge.
- R3: A transaction fires in a cycle only when all of these hold: `busy` is high, `src_empty` is low, `snk_full` is low and `rdy_in[rdy_sel]` is high. In that cycle `src_rd` and `snk_wr` are both high and `snk_data` equals `src_data`. In every other cycle both strobes are low.
- R4: Each fired transaction lowers `count` by exactly one at the following clock edge.
- R5: When any firing condition is missing, no transaction fires and `count` holds. Transfers resume on their own once all the conditions are met again.
- R6: The transaction that takes `count` from 1 to 0 makes `busy` fall and `done` rise at the next clock edge.
- R7: A `start` given while not busy with `count` equal to 0 raises `done` at the next edge, leaves `busy` low and moves no data.
- R8: `done` stays high until a `start` is given. A `start` with a non-zero count clears `done` and raises `busy` at the next edge.
- R9: Count writes while `busy` is high have no effect on `count`.
- R10: A `start` pulse while `busy` is high has no effect.
- R11: `ctl_strobe` is at its active level (high for the default parameter) exactly in the cycles in which a transaction fires. It can therefore change level on consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_wr_en | input | 1 | Write one byte lane of the count |
| cnt_wr_sel | input | 2 | Byte lane select, 0 = least significant |
| cnt_wr_data | input | 8 | Byte to write |
| start | input | 1 | Begin a counted run |
| rdy_sel | input | 1 | Selects which ready input gates transfers |
| rdy_in | input | 2 | Ready inputs |
| src_empty | input | 1 | Source has no data |
| src_data | input | 8 | Byte at the head of the source |
| src_rd | output | 1 | Pop the source this cycle |
| snk_full | input | 1 | Sink has no room |
| snk_wr | output | 1 | Push into the sink this cycle |
| snk_data | output | 8 | Byte pushed into the sink |
| count | output | 32 | Transactions still outstanding |
| busy | output | 1 | Run in progress |
| done | output | 1 | Sticky completion flag |
| ctl_strobe | output | 1 | Control strobe marking transaction cycles |

## Verification
The checker watches several behaviours on every cycle. It confirms that the source is never popped while empty, that the sink is never pushed while full, and that strobes occur only while busy. It also checks the one-per-transaction decrement, that the count holds in busy cycles with no transfer (which covers writes ignored during a run), the finish on the last transaction, the zero-count start and the stickiness of `done`. Other behaviours can only be shown by the bench's scenarios. These are the byte-lane mapping of the count writes, whether data passes through unchanged, the exact number of bytes moved per run, automatic resumption after each kind of stall, the ignored restart and the strobe toggling on alternate cycles.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/xfer_seq_count.sv
// Transaction counter: byte-lane loads while idle, decrement per transaction.
module xfer_seq_count #(
    parameter int CNT_BYTES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(CNT_BYTES)-1:0] wr_sel,
    input  logic [7:0]                   wr_data,
    input  logic                         load_ok,
    input  logic                         dec,
    output logic [CNT_BYTES*8-1:0]       cnt,
    output logic                         cnt_zero,
    output logic                         cnt_one
);
    localparam int CNT_W = CNT_BYTES * 8;
    localparam int SEL_W = $clog2(CNT_BYTES);

    logic [CNT_W-1:0] cnt_less;

    always_comb begin
        cnt_less = cnt - CNT_W'(1);
        cnt_zero = (cnt == '0);
        cnt_one  = (cnt == CNT_W'(1));
    end

    for (genvar g = 0; g < CNT_BYTES; g++) begin : g_lane
        logic lane_wr;
        always_comb lane_wr = wr_en && load_ok && (wr_sel == SEL_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt[g*8 +: 8] <= 8'h00;
            end else if (dec) begin
                cnt[g*8 +: 8] <= cnt_less[g*8 +: 8];
            end else if (lane_wr) begin
                cnt[g*8 +: 8] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/xfer_seq_gate.sv
// Transfer gate: decides whether a transaction fires this cycle.
module xfer_seq_gate #(
    parameter int RDY_N          = 2,
    parameter int DATA_W         = 8,
    parameter bit STROBE_ACT_LOW = 1'b0
) (
    input  logic                     running,
    input  logic                     src_empty,
    input  logic                     snk_full,
    input  logic [RDY_N-1:0]         rdy_in,
    input  logic [$clog2(RDY_N)-1:0] rdy_sel,
    input  logic [DATA_W-1:0]        src_data,
    output logic                     fire,
    output logic [DATA_W-1:0]        snk_data,
    output logic                     strobe
);
    logic rdy_pick;

    always_comb begin
        rdy_pick = rdy_in[rdy_sel];
        fire     = running && !src_empty && !snk_full && rdy_pick;
        snk_data = src_data;
        strobe   = fire ^ STROBE_ACT_LOW;
    end
endmodule

// File: rtl/xfer_seq_fsm.sv
// Run control: IDLE -> RUN -> DONE, restartable from IDLE or DONE.
module xfer_seq_fsm
    import xfer_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic fire,
    input  logic cnt_zero,
    input  logic cnt_one,
    output logic running,
    output logic finished
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    state_d = cnt_zero ? ST_DONE : ST_RUN;
                end
            end
            ST_RUN: begin
                if (fire && cnt_one) begin
                    state_d = ST_DONE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        running  = 1'b0;
        finished = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  running  = 1'b1;
            ST_DONE: finished = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq #(
    parameter int CNT_BYTES      = 4,
    parameter int DATA_W         = 8,
    parameter int RDY_N          = 2,
    parameter bit STROBE_ACT_LOW = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cnt_wr_en,
    input  logic [$clog2(CNT_BYTES)-1:0] cnt_wr_sel,
    input  logic [7:0]                   cnt_wr_data,
    input  logic                         start,
    input  logic [$clog2(RDY_N)-1:0]     rdy_sel,
    input  logic [RDY_N-1:0]             rdy_in,
    input  logic                         src_empty,
    input  logic [DATA_W-1:0]            src_data,
    output logic                         src_rd,
    input  logic                         snk_full,
    output logic                         snk_wr,
    output logic [DATA_W-1:0]            snk_data,
    output logic [CNT_BYTES*8-1:0]       count,
    output logic                         busy,
    output logic                         done,
    output logic                         ctl_strobe
);
    logic running;
    logic finished;
    logic fire;
    logic cnt_zero;
    logic cnt_one;

    xfer_seq_gate #(
        .RDY_N          (RDY_N),
        .DATA_W         (DATA_W),
        .STROBE_ACT_LOW (STROBE_ACT_LOW)
    ) u_gate (
        .running   (running),
        .src_empty (src_empty),
        .snk_full  (snk_full),
        .rdy_in    (rdy_in),
        .rdy_sel   (rdy_sel),
        .src_data  (src_data),
        .fire      (fire),
        .snk_data  (snk_data),
        .strobe    (ctl_strobe)
    );

    xfer_seq_count #(
        .CNT_BYTES (CNT_BYTES)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cnt_wr_en),
        .wr_sel   (cnt_wr_sel),
        .wr_data  (cnt_wr_data),
        .load_ok  (!running),
        .dec      (fire),
        .cnt      (count),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one)
    );

    xfer_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .fire     (fire),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one),
        .running  (running),
        .finished (finished)
    );

    always_comb begin
        src_rd = fire;
        snk_wr = fire;
        busy   = running;
        done   = finished;
    end
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             src_empty,
    input logic             snk_full,
    input logic             src_rd,
    input logic             snk_wr,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] count
);
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd |-> !src_empty);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        snk_wr |-> !snk_full);

    assert_fire_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rd || snk_wr) |-> busy);

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && src_rd) |=> (count == $past(count) - CNT_W'(1)));

    assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !src_rd) |=> $stable(count));

    assert_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && src_rd && count == CNT_W'(1)) |=> (done && !busy));

    assert_zero_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && count == '0) |=> (done && !busy));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
endmodule

bind xfer_seq xfer_seq_chk #(.CNT_W(CNT_BYTES*8)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .src_empty (src_empty),
    .snk_full  (snk_full),
    .src_rd    (src_rd),
    .snk_wr    (snk_wr),
    .busy      (busy),
    .done      (done),
    .count     (count)
);

// File: tb/xfer_seq_tb.sv
module xfer_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_wr_en = 1'b0;
    logic [1:0]  cnt_wr_sel = '0;
    logic [7:0]  cnt_wr_data = '0;
    logic        start = 1'b0;
    logic [0:0]  rdy_sel = '0;
    logic [1:0]  rdy_in = 2'b11;
    logic        src_empty = 1'b0;
    logic [7:0]  src_data = 8'h5A;
    logic        src_rd;
    logic        snk_full = 1'b0;
    logic        snk_wr;
    logic [7:0]  snk_data;
    logic [31:0] count;
    logic        busy;
    logic        done;
    logic        ctl_strobe;

    int checks = 0;
    int errors = 0;
    int xfers = 0;
    int bad_r3 = 0;
    int bad_r11 = 0;

    always #10 clk = ~clk;

    xfer_seq u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_wr_en   (cnt_wr_en),
        .cnt_wr_sel  (cnt_wr_sel),
        .cnt_wr_data (cnt_wr_data),
        .start       (start),
        .rdy_sel     (rdy_sel),
        .rdy_in      (rdy_in),
        .src_empty   (src_empty),
        .src_data    (src_data),
        .src_rd      (src_rd),
        .snk_full    (snk_full),
        .snk_wr      (snk_wr),
        .snk_data    (snk_data),
        .count       (count),
        .busy        (busy),
        .done        (done),
        .ctl_strobe  (ctl_strobe)
    );

    // Mid-cycle monitor: inputs change just after posedge, so negedge is stable.
    always @(negedge clk) begin
        if (rst_n) begin
            if (src_rd) xfers++;
            if (snk_wr !== src_rd) bad_r3++;
            if (src_rd && (snk_data !== src_data)) bad_r3++;
            if (src_rd && (src_empty || snk_full || !rdy_in[rdy_sel] || !busy)) bad_r3++;
            if (!src_rd && busy && !src_empty && !snk_full && rdy_in[rdy_sel]) bad_r3++;
            if (ctl_strobe !== src_rd) bad_r11++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_lane(input logic [1:0] sel, input logic [7:0] val);
        cnt_wr_sel  = sel;
        cnt_wr_data = val;
        cnt_wr_en   = 1'b1;
        step(1);
        cnt_wr_en   = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        step(1);
        start = 1'b0;
        #2;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        #2;
        chk(count == 32'h0, "R1", "count after reset", count, 32'h0);
        chk({busy, done} == 2'b00, "R1", "busy/done after reset", {busy, done}, 2'b00);
        chk({src_rd, snk_wr, ctl_strobe} == 3'b000, "R1", "strobes after reset",
            {src_rd, snk_wr, ctl_strobe}, 3'b000);
    endtask

    task automatic t_lanes();
        wr_lane(2'd0, 8'hD4);
        wr_lane(2'd1, 8'hC3);
        wr_lane(2'd2, 8'hB2);
        wr_lane(2'd3, 8'hA1);
        #2;
        chk(count == 32'hA1B2C3D4, "R2", "lane-mapped count", count, 32'hA1B2C3D4);
        wr_lane(2'd3, 8'h00);
        #2;
        chk(count == 32'h00B2C3D4, "R2", "top lane rewrite", count, 32'h00B2C3D4);
    endtask

    task automatic t_free_run();
        int x0;
        wr_lane(2'd2, 8'h00);
        wr_lane(2'd1, 8'h00);
        wr_lane(2'd0, 8'h05);
        x0 = xfers;
        src_empty = 1'b0; snk_full = 1'b0; rdy_sel = 1'b0; rdy_in = 2'b01;
        src_data = 8'h3C;
        pulse_start();
        chk(busy && !done, "R8", "busy after start", {busy, done}, 2'b10);
        chk(count == 32'd5, "R4", "count at run start", count, 32'd5);
        step(2); #2;
        chk(count == 32'd3, "R4", "count after two transfers", count, 32'd3);
        step(3); #2;
        chk(done && !busy, "R6", "done after last transfer", {busy, done}, 2'b01);
        chk(count == 32'd0, "R6", "count at finish", count, 32'd0);
        chk(xfers - x0 == 5, "R4", "bytes moved", xfers - x0, 5);
        chk(bad_r3 == 0, "R3", "fire condition and data path", bad_r3, 0);
    endtask

    task automatic t_stalls();
        int x0;
        wr_lane(2'd0, 8'h06);
        x0 = xfers;
        src_empty = 1'b1;
        pulse_start();
        step(3); #2;
        chk(count == 32'd6 && xfers == x0, "R5", "stall on empty source", count, 32'd6);
        wr_lane(2'd0, 8'hFF);
        #2;
        chk(count == 32'd6, "R9", "write ignored while busy", count, 32'd6);
        pulse_start();
        chk(busy && !done && count == 32'd6, "R10", "restart ignored while busy",
            {busy, done, count[5:0]}, {2'b10, 6'd6});
        src_empty = 1'b0; snk_full = 1'b1;
        step(2); #2;
        chk(count == 32'd6 && xfers == x0, "R5", "stall on full sink", count, 32'd6);
        snk_full = 1'b0; rdy_sel = 1'b1; rdy_in = 2'b01;
        step(2); #2;
        chk(count == 32'd6 && xfers == x0, "R5", "stall on selected ready low", count, 32'd6);
        rdy_in = 2'b10;
        step(6); #2;
        chk(done && count == 32'd0 && xfers - x0 == 6, "R5", "automatic resume to finish",
            xfers - x0, 6);
    endtask

    task automatic t_zero_and_sticky();
        int x0;
        x0 = xfers;
        pulse_start();
        chk(done && !busy, "R7", "zero-count start finishes", {busy, done}, 2'b01);
        chk(xfers == x0, "R7", "no data moved on zero count", xfers - x0, 0);
        step(5); #2;
        chk(done, "R8", "done held while no start", done, 1'b1);
        wr_lane(2'd0, 8'h02);
        #2;
        chk(done && count == 32'd2, "R8", "done held across count write", {done, count[1:0]}, 3'b110);
        pulse_start();
        chk(!done && busy, "R8", "done cleared by start", {busy, done}, 2'b10);
        step(2); #2;
        chk(done && count == 32'd0, "R6", "second run finishes", count, 32'd0);
    endtask

    task automatic t_strobe_toggle();
        int x0;
        wr_lane(2'd0, 8'h04);
        x0 = xfers;
        rdy_in = 2'b11;
        src_empty = 1'b0;
        pulse_start();
        for (int i = 0; i < 8; i++) begin
            src_empty = i[0];
            step(1);
        end
        #2;
        chk(done && xfers - x0 == 4, "R11", "alternating strobe run", xfers - x0, 4);
        chk(bad_r11 == 0, "R11", "strobe matches transfer cycles", bad_r11, 0);
        chk(bad_r3 == 0, "R3", "gating across all scenarios", bad_r3, 0);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_lanes();
        t_free_run();
        t_stalls();
        t_zero_and_sticky();
        t_strobe_toggle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule